// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Sequencer

This block decides when a processor core leaves its instruction stream to service an interrupt, and it fetches the service pointer for that interrupt. Two request sources feed it. The maskable request is level sensitive and is gated by the core's interrupt-enable flag. The non-maskable request is edge sensitive, and once its rising edge is caught it stays latched until it is serviced. Both requests are only considered when the core raises its instruction-boundary strobe.

For a maskable request, the block runs a pair of acknowledge bus cycles back to back. It releases the local data bus during both cycles and takes the 8-bit interrupt type from the low data lines in the second cycle. A non-maskable request skips the acknowledge pair and uses the fixed type 2. In both cases the type, scaled by four, selects a 4-byte entry in the low-memory pointer table. The block reads the offset word at the entry base, then the segment word two bytes above it. Once both words are held on its outputs, it pulses a service-start strobe.

The bus side is a simple request/done handshake. The sequencer holds one request and its address until the bus agent returns a one-cycle done. At most one request is active at a time.

Top module: `irq_ack_sequencer`

## Requirements
- R1: A maskable request is taken only on a clock edge where the boundary strobe is high, the enable flag is high and the request has passed through the SYNC_STAGES-flop synchroniser. A request that first rises in the same cycle as the strobe is not taken. A request present while the enable flag is low has no effect, and so does a request present without a strobe.
- R2: A taken maskable request runs exactly two acknowledge cycles back to back. `ack_req` stays high through both, `ack_second` is high only in the second, and `bus_release` is high throughout.
- R3: The type is captured from `bus_data[7:0]` when the second acknowledge cycle completes. Data returned in the first cycle and on bits 15:8 is ignored.
- R4: Both table reads use addresses below 0x400. The offset read goes to type*4 and the segment read to type*4+2, with every address bit above bit 9 zero.
- R5: The offset word is read before the segment word. Each word is presented on `vec_offset` or `vec_segment` exactly as it was returned.
- R6: `svc_start` is a one-cycle pulse in the cycle after the segment read completes. In that cycle `svc_type`, `vec_offset` and `vec_segment` hold the result of the sequence.
- R7: A rising edge of the non-maskable request is latched until a boundary takes it. Its service uses type 2, reads addresses 8 and 10, and runs no acknowledge cycles.
- R8: When both sources are pending at the same boundary, the non-maskable one is serviced first. A still-pending maskable request is taken at a later boundary.
- R9: A non-maskable request that is already high before the second clock after reset release, and is held, is never honoured.
- R10: Holding the non-maskable request high after it has been serviced does not request service again. A new rising edge is needed.
- R11: While a sequence is in progress, boundary strobes are ignored. Each bus request holds its address steady until `bus_done`, and `ack_req` and `rd_req` are never high together.
- R12: During reset and right after it, all request, release and strobe outputs are low, and `svc_type`, `vec_offset` and `vec_segment` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_req | input | 1 | Maskable request, level sensitive, asynchronous |
| nmi_req | input | 1 | Non-maskable request, edge sensitive, asynchronous |
| int_enable | input | 1 | Interrupt-enable flag of the core |
| insn_boundary | input | 1 | One-cycle strobe at an instruction boundary |
| bus_done | input | 1 | Completion of the current bus request |
| bus_data | input | 16 | Read data; type byte on bits 7:0 during acknowledge |
| ack_req | output | 1 | Acknowledge cycle request |
| ack_second | output | 1 | Marks the second acknowledge cycle |
| bus_release | output | 1 | Local data bus released by the core |
| rd_req | output | 1 | Pointer-table word read request |
| rd_addr | output | 20 | Byte address of the table word being read |
| svc_type | output | 8 | Type of the interrupt being serviced |
| vec_offset | output | 16 | Fetched offset word |
| vec_segment | output | 16 | Fetched segment word |
| svc_start | output | 1 | One-cycle pulse: pointer ready, service begins |

## Verification
The bench sweeps all 256 type values through the maskable path and varies the bus wait states. It returns deliberately wrong data in the first acknowledge cycle and on the high byte, so a design that reads the wrong cycle or the wrong lane, scales the type wrongly or swaps the two table reads ends up with wrong pointer words. The non-maskable path is tested in several ways: held high across reset, pulsed while idle, pulsed during a maskable sequence and held after service. A design that arms too early, loses the latch or responds to level rather than edge would service too often or too rarely. Simultaneous pending sources check that the non-maskable one wins and that the maskable one is not dropped. A rise on the same cycle as the boundary strobe checks that the synchroniser delay is respected.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int DEF_ADDR_W      = 20;
    localparam int DEF_DATA_W      = 16;
    localparam int DEF_TYPE_W      = 8;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_NMI_ARM     = 2;
    localparam logic [7:0] NMI_FIXED_TYPE = 8'd2;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ACK_FIRST,
        SEQ_ACK_SECOND,
        SEQ_READ_OFS,
        SEQ_READ_SEG
    } seq_state_t;

    typedef struct packed {
        logic take_nmi;
        logic take_mask;
    } grant_t;

    function automatic grant_t arbitrate(input logic idle, input logic strobe,
                                         input logic nmi_pend, input logic mask_ok);
        grant_t g;
        g.take_nmi  = idle & strobe & nmi_pend;
        g.take_mask = idle & strobe & ~nmi_pend & mask_ok;
        return g;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES:0] chain;
    assign chain[0] = d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i+1] <= 1'b0;
            else     chain[i+1] <= chain[i];
        end
    end

    assign q = chain[STAGES];
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
    parameter int ARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_s,
    input  logic clear,
    output logic pending
);
    localparam int CW = $clog2(ARM_CYCLES + 1);

    logic [CW-1:0] arm_cnt;
    logic          armed;
    logic          prev;
    logic          rise_ok;

    assign armed   = (arm_cnt == CW'(ARM_CYCLES));
    assign rise_ok = armed & nmi_s & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_cnt <= '0;
            prev    <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (!armed) arm_cnt <= arm_cnt + 1'b1;
            prev    <= nmi_s;
            pending <= (pending & ~clear) | rise_ok;
        end
    end
endmodule

// File: rtl/irq_vector_fsm.sv
module irq_vector_fsm
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_t            grant,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_data,
    output logic              idle,
    output logic              ack_req,
    output logic              ack_second,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TYPE_W-1:0] svc_type,
    output logic [DATA_W-1:0] vec_offset,
    output logic [DATA_W-1:0] vec_segment,
    output logic              svc_start
);
    localparam int PAD_W = ADDR_W - TYPE_W - 2;

    seq_state_t        state;
    logic [TYPE_W-1:0] type_q;

    assign idle       = (state == SEQ_IDLE);
    assign ack_req    = (state == SEQ_ACK_FIRST) || (state == SEQ_ACK_SECOND);
    assign ack_second = (state == SEQ_ACK_SECOND);
    assign rd_req     = (state == SEQ_READ_OFS) || (state == SEQ_READ_SEG);
    assign rd_addr    = {{PAD_W{1'b0}}, type_q, (state == SEQ_READ_SEG), 1'b0};
    assign svc_type   = type_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            type_q      <= '0;
            vec_offset  <= '0;
            vec_segment <= '0;
            svc_start   <= 1'b0;
        end else begin
            svc_start <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (grant.take_nmi) begin
                        type_q <= TYPE_W'(NMI_FIXED_TYPE);
                        state  <= SEQ_READ_OFS;
                    end else if (grant.take_mask) begin
                        state  <= SEQ_ACK_FIRST;
                    end
                end
                SEQ_ACK_FIRST: begin
                    if (bus_done) state <= SEQ_ACK_SECOND;
                end
                SEQ_ACK_SECOND: begin
                    if (bus_done) begin
                        type_q <= bus_data[TYPE_W-1:0];
                        state  <= SEQ_READ_OFS;
                    end
                end
                SEQ_READ_OFS: begin
                    if (bus_done) begin
                        vec_offset <= bus_data;
                        state      <= SEQ_READ_SEG;
                    end
                end
                SEQ_READ_SEG: begin
                    if (bus_done) begin
                        vec_segment <= bus_data;
                        svc_start   <= 1'b1;
                        state       <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int TYPE_W      = DEF_TYPE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int NMI_ARM     = DEF_NMI_ARM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              intr_req,
    input  logic              nmi_req,
    input  logic              int_enable,
    input  logic              insn_boundary,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ack_req,
    output logic              ack_second,
    output logic              bus_release,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TYPE_W-1:0] svc_type,
    output logic [DATA_W-1:0] vec_offset,
    output logic [DATA_W-1:0] vec_segment,
    output logic              svc_start
);
    localparam int ARM_TOTAL = NMI_ARM + SYNC_STAGES;

    logic   intr_s;
    logic   nmi_s;
    logic   nmi_pend;
    logic   idle;
    grant_t grant;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_intr (
        .clk(clk), .rst(rst), .d(intr_req), .q(intr_s)
    );

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_nmi (
        .clk(clk), .rst(rst), .d(nmi_req), .q(nmi_s)
    );

    irq_nmi_latch #(.ARM_CYCLES(ARM_TOTAL)) u_nmi (
        .clk(clk), .rst(rst), .nmi_s(nmi_s),
        .clear(grant.take_nmi), .pending(nmi_pend)
    );

    assign grant = arbitrate(idle, insn_boundary, nmi_pend, intr_s & int_enable);

    irq_vector_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .grant(grant),
        .bus_done(bus_done), .bus_data(bus_data),
        .idle(idle), .ack_req(ack_req), .ack_second(ack_second),
        .rd_req(rd_req), .rd_addr(rd_addr), .svc_type(svc_type),
        .vec_offset(vec_offset), .vec_segment(vec_segment),
        .svc_start(svc_start)
    );

    assign bus_release = ack_req;
endmodule

// File: rtl/irq_ack_sequencer_chk.sv
module irq_ack_sequencer_chk #(
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_done,
    input logic              ack_req,
    input logic              ack_second,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              svc_start
);
    assert_one_request_R11: assert property (@(posedge clk) disable iff (rst)
        !(ack_req && rd_req));

    assert_ack_held_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !bus_done) |=> (ack_req && $stable(ack_second)));

    assert_addr_held_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !bus_done) |=> (rd_req && $stable(rd_addr)));

    assert_second_follows_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_second) |-> $past(ack_req && !ack_second && bus_done));

    assert_table_range_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[ADDR_W-1:TYPE_W+2] == '0 && rd_addr[0] == 1'b0));

    assert_start_after_seg_R6: assert property (@(posedge clk) disable iff (rst)
        svc_start |-> $past(rd_req && bus_done && rd_addr[1]));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        svc_start |=> !svc_start);
endmodule

bind irq_ack_sequencer irq_ack_sequencer_chk #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_chk (
    .clk(clk), .rst(rst), .bus_done(bus_done), .ack_req(ack_req),
    .ack_second(ack_second), .rd_req(rd_req), .rd_addr(rd_addr),
    .svc_start(svc_start)
);

// File: tb/tb_irq_ack_sequencer.sv
module tb_irq_ack_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        intr_req = 1'b0, nmi_req = 1'b0, int_enable = 1'b0, insn_boundary = 1'b0;
    logic        bus_done = 1'b0;
    logic [15:0] bus_data = 16'h0;
    logic        ack_req, ack_second, bus_release, rd_req, svc_start;
    logic [19:0] rd_addr;
    logic [7:0]  svc_type;
    logic [15:0] vec_offset, vec_segment;

    int checks = 0, errors = 0;
    int n_ack = 0, n_rd = 0, n_svc = 0, wait_states = 0, ws_cnt = 0;
    logic [7:0]  cur_type = 8'h0;
    logic [19:0] addr_ofs = '0, addr_seg = '0;
    bit          ack_ok = 1'b1;

    irq_ack_sequencer dut (.*);

    always #4 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return (a[15:0] * 16'd97) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus agent: answers requests after wait_states cycles, records traffic
    initial begin
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            if (svc_start) n_svc++;
            if (ack_req || rd_req) begin
                if (ack_req && !bus_release) ack_ok = 1'b0;
                if (ws_cnt >= wait_states) begin
                    ws_cnt = 0;
                    bus_done = 1'b1;
                    if (ack_req) begin
                        if (ack_second != (n_ack % 2 == 1)) ack_ok = 1'b0;
                        bus_data = ack_second ? {8'hEE, cur_type} : {8'hC3, ~cur_type};
                        n_ack++;
                    end else begin
                        bus_data = mem_word(rd_addr);
                        if (rd_addr[1]) addr_seg = rd_addr; else addr_ofs = rd_addr;
                        n_rd++;
                    end
                end else begin
                    ws_cnt++;
                end
            end
        end
    end

    task automatic clear_counts();
        n_ack = 0; n_rd = 0; n_svc = 0; ack_ok = 1'b1;
    endtask

    task automatic strobe();
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    task automatic expect_service(input logic [7:0] t, input int acks, input string req);
        int guard = 0;
        while (!svc_start && guard < 200) begin @(negedge clk); guard++; end
        chk(guard < 200, {req, " service start seen"}, guard, 200);
        chk(svc_type == t, {req, " type"}, svc_type, t);
        chk(n_ack == acks && ack_ok, {req, " acknowledge cycles"}, n_ack, acks);
        chk(addr_ofs == {10'd0, t, 2'b00}, "R4 offset address", addr_ofs, {10'd0, t, 2'b00});
        chk(addr_seg == {10'd0, t, 2'b10}, "R4 segment address", addr_seg, {10'd0, t, 2'b10});
        chk(vec_offset == mem_word({10'd0, t, 2'b00}), "R5 offset word", vec_offset, mem_word({10'd0, t, 2'b00}));
        chk(vec_segment == mem_word({10'd0, t, 2'b10}), "R5 segment word", vec_segment, mem_word({10'd0, t, 2'b10}));
        @(negedge clk);
        chk(!svc_start, "R6 single pulse", svc_start, 0);
    endtask

    initial begin
        // R12 / R9: reset with the non-maskable request already high
        nmi_req = 1'b1;
        repeat (5) @(negedge clk);
        chk({ack_req, rd_req, bus_release, svc_start} == 4'b0, "R12 outputs in reset",
            {ack_req, rd_req, bus_release, svc_start}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({svc_type, vec_offset, vec_segment} == 40'h0, "R12 values after reset",
            {svc_type, vec_offset, vec_segment}, 0);
        clear_counts();
        repeat (20) @(negedge clk);
        strobe();
        repeat (30) @(negedge clk);
        chk(n_rd == 0 && n_svc == 0, "R9 early level not honoured", n_rd, 0);
        nmi_req = 1'b0;

        // R1: disabled, no strobe, and same-cycle rise
        intr_req = 1'b1; int_enable = 1'b0;
        repeat (4) @(negedge clk);
        strobe();
        repeat (30) @(negedge clk);
        chk(n_ack == 0 && n_svc == 0, "R1 ignored while disabled", n_ack, 0);
        int_enable = 1'b1;
        repeat (30) @(negedge clk);
        chk(n_ack == 0 && n_svc == 0, "R1 ignored without boundary", n_ack, 0);
        intr_req = 1'b0;
        repeat (4) @(negedge clk);
        intr_req = 1'b1; insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0; intr_req = 1'b0;
        repeat (30) @(negedge clk);
        chk(n_ack == 0, "R1 unsynchronised request not taken", n_ack, 0);

        // R2 R3 R4 R5 R6: sweep every type with varying wait states
        for (int t = 0; t < 256; t++) begin
            clear_counts();
            wait_states = t % 3;
            cur_type = 8'(t);
            intr_req = 1'b1;
            repeat (3) @(negedge clk);
            strobe();
            intr_req = 1'b0;
            expect_service(8'(t), 2, "R2 R3 sweep");
        end
        wait_states = 0;

        // R7 / R10: pulse edge latched, then held level does not retrigger
        clear_counts();
        nmi_req = 1'b1;
        repeat (10) @(negedge clk);
        strobe();
        expect_service(8'd2, 0, "R7 non-maskable");
        clear_counts();
        repeat (5) @(negedge clk);
        strobe();
        repeat (30) @(negedge clk);
        chk(n_svc == 0, "R10 held level no retrigger", n_svc, 0);
        nmi_req = 1'b0;
        repeat (5) @(negedge clk);

        // R8: both pending at one boundary
        clear_counts();
        cur_type = 8'h5A;
        intr_req = 1'b1;
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        repeat (6) @(negedge clk);
        strobe();
        expect_service(8'd2, 0, "R8 non-maskable first");
        clear_counts();
        strobe();
        intr_req = 1'b0;
        expect_service(8'h5A, 2, "R8 maskable afterwards");

        // R11: strobes ignored mid-sequence; R7 edge during sequence latched
        clear_counts();
        wait_states = 3;
        cur_type = 8'h33;
        intr_req = 1'b1;
        repeat (3) @(negedge clk);
        strobe();
        intr_req = 1'b0;
        nmi_req = 1'b1;
        for (int k = 0; k < 4; k++) strobe();
        nmi_req = 1'b0;
        expect_service(8'h33, 2, "R11 sequence completes");
        repeat (30) @(negedge clk);
        chk(n_svc == 1, "R11 no service without new boundary", n_svc, 1);
        clear_counts();
        wait_states = 0;
        strobe();
        expect_service(8'd2, 0, "R7 latched during sequence");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule